// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a small 32-bit processor core that runs each instruction as a series of short clock steps. It does not use one long cycle per instruction. One memory port serves both instruction fetch and data access. One ALU is shared across the steps: it increments the PC, forms the branch target and performs the operation. Hidden registers carry values from one step to the next: the instruction register, the two operand latches, the ALU result latch and the memory data latch.

A control state machine sequences the steps. The states are FETCH, DECODE, EXEC_R, EXEC_I, ADDR, BRANCH, WB_R, WB_I, MEM_RD, MEM_WR and WB_LD. The transitions are:

- FETCH goes to DECODE.
- DECODE goes to EXEC_R for a known R-type, EXEC_I for add-immediate, ADDR for load or store, BRANCH for branch-if-equal, and back to FETCH for anything else.
- EXEC_R goes to WB_R, and EXEC_I goes to WB_I.
- ADDR goes to MEM_RD for a load and to MEM_WR for a store.
- MEM_RD goes to WB_LD.
- BRANCH, WB_R, WB_I, MEM_WR and WB_LD all return to FETCH.

The memory read is combinational: `mem_rdata` must present the word at `mem_addr` within the same cycle. A store is committed at the clock edge that ends the cycle in which `mem_we` is high.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and in the cycle after release, the core is in FETCH with PC 0. `mem_addr` reads 0 and `mem_we` is low. All general registers reset to zero.
- R2: Every instruction starts with one fetch cycle. In that cycle `mem_addr` equals PC and `mem_we` is low. The fetched word goes into the instruction register, and PC advances by 4. Field positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0].
- R3: Opcode 0x00 is R-type and takes 4 cycles. It writes rd with rs op rt. The funct codes are add 0x20, subtract 0x22, and 0x24, or 0x25, and signed set-less-than 0x2A.
- R4: Opcode 0x08 (add-immediate) takes 4 cycles. It writes rt with rs plus the sign-extended immediate.
- R5: Opcode 0x23 (load word) takes 5 cycles. The address is rs plus the sign-extended immediate. It is presented in the fourth cycle, and the data read there is written into rt in the fifth.
- R6: Opcode 0x2B (store word) takes 4 cycles. In the fourth cycle it drives `mem_we` high for exactly one cycle, with the address rs plus the sign-extended immediate and the data rt.
- R7: Opcode 0x04 (branch-if-equal) takes 3 cycles. If rs equals rt, the next PC is PC+4+(sign-extended immediate × 4), which may point backwards. Otherwise the next PC is PC+4.
- R8: Register 0 always reads as zero. Writes to it from any instruction class have no effect.
- R9: An unknown opcode, or an R-type with an unknown funct, returns to FETCH after DECODE (2 cycles). It changes no register, memory word or PC beyond the +4 advance.
- R10: `mem_we` is high only in the data cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, one cycle per store |
| mem_rdata | input | 32 | Word read at `mem_addr`, same cycle |

## Verification
The hardest behaviour to observe is a register write that must not happen. This covers writes to register 0 and the effect of an illegal opcode or funct. The register file is not visible at the ports. The program therefore aims an illegal funct at a live destination, writes register 0 by both add-immediate and load, and skips an instruction with a taken branch. It then stores each affected register to memory, where the bus trace and the final memory contents expose any stray write.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_EXEC_R, S_EXEC_I, S_ADDR, S_BRANCH,
        S_WB_R, S_WB_I, S_MEM_RD, S_MEM_WR, S_WB_LD
    } state_t;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_t;
    typedef enum logic       {ASRC_PC, ASRC_A} asrc_t;
    typedef enum logic [1:0] {BSRC_B, BSRC_STEP, BSRC_IMM, BSRC_BRIMM} bsrc_t;
    typedef enum logic       {DST_RD, DST_RT} dst_t;
    typedef enum logic       {WSRC_ALUOUT, WSRC_MDR} wsrc_t;
    typedef enum logic       {MADDR_PC, MADDR_ALUOUT} maddr_t;
    typedef enum logic       {PCSRC_ALU, PCSRC_ALUOUT} pcsrc_t;

    typedef struct packed {
        logic    pc_we;
        pcsrc_t  pc_src;
        logic    ir_we;
        logic    ab_we;
        logic    aluout_we;
        logic    mdr_we;
        logic    rf_we;
        dst_t    rf_dst;
        wsrc_t   rf_src;
        maddr_t  mem_src;
        logic    mem_we;
        asrc_t   alu_a;
        bsrc_t   alu_b;
        alu_op_t alu_op;
    } ctrl_t;

    function automatic logic funct_known(input logic [5:0] fn);
        return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
               (fn == FN_OR)  || (fn == FN_SLT);
    endfunction

    function automatic alu_op_t funct_to_op(input logic [5:0] fn);
        alu_op_t r;
        unique case (fn)
            FN_SUB:  r = ALU_SUB;
            FN_AND:  r = ALU_AND;
            FN_OR:   r = ALU_OR;
            FN_SLT:  r = ALU_SLT;
            default: r = ALU_ADD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  alu_op_t         op,
    output logic [XLEN-1:0] result,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: result = op_a + op_b;
            ALU_SUB: result = op_a - op_b;
            ALU_AND: result = op_a & op_b;
            ALU_OR:  result = op_a | op_b;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
            default: result = '0;
        endcase
    end

    assign zero = (result == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_addr_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_a,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data
);

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs[g] <= '0;
                else        regs[g] <= '0;
            end
        end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                regs[g] <= '0;
                else if (wr_en && (wr_addr == AW'(g)))     regs[g] <= wr_data;
            end
        end
    end

    assign rd_data_a = regs[rd_addr_a];
    assign rd_data_b = regs[rd_addr_b];

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (regs[0] == '0)); // R8

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       alu_zero,
    output ctrl_t      ctrl_o,
    output state_t     state_o
);

    state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = S_FETCH;
        unique case (state_q)
            S_FETCH:  state_d = S_DECODE;
            S_DECODE: begin
                if (opcode == OP_RTYPE && funct_known(funct)) state_d = S_EXEC_R;
                else if (opcode == OP_ADDI)                   state_d = S_EXEC_I;
                else if (opcode == OP_LW || opcode == OP_SW)  state_d = S_ADDR;
                else if (opcode == OP_BEQ)                    state_d = S_BRANCH;
                else                                          state_d = S_FETCH;
            end
            S_EXEC_R: state_d = S_WB_R;
            S_EXEC_I: state_d = S_WB_I;
            S_ADDR:   state_d = (opcode == OP_LW) ? S_MEM_RD : S_MEM_WR;
            S_MEM_RD: state_d = S_WB_LD;
            S_BRANCH, S_WB_R, S_WB_I, S_MEM_WR, S_WB_LD: state_d = S_FETCH;
            default:  state_d = S_FETCH;
        endcase
    end

    always_comb begin
        ctrl_o = '{pc_we: 1'b0, pc_src: PCSRC_ALU, ir_we: 1'b0, ab_we: 1'b0,
                   aluout_we: 1'b0, mdr_we: 1'b0, rf_we: 1'b0, rf_dst: DST_RD,
                   rf_src: WSRC_ALUOUT, mem_src: MADDR_PC, mem_we: 1'b0,
                   alu_a: ASRC_PC, alu_b: BSRC_STEP, alu_op: ALU_ADD};
        unique case (state_q)
            S_FETCH: begin
                ctrl_o.ir_we = 1'b1;
                ctrl_o.pc_we = 1'b1;
            end
            S_DECODE: begin
                ctrl_o.ab_we     = 1'b1;
                ctrl_o.alu_b     = BSRC_BRIMM;
                ctrl_o.aluout_we = 1'b1;
            end
            S_EXEC_R: begin
                ctrl_o.alu_a     = ASRC_A;
                ctrl_o.alu_b     = BSRC_B;
                ctrl_o.alu_op    = funct_to_op(funct);
                ctrl_o.aluout_we = 1'b1;
            end
            S_EXEC_I, S_ADDR: begin
                ctrl_o.alu_a     = ASRC_A;
                ctrl_o.alu_b     = BSRC_IMM;
                ctrl_o.aluout_we = 1'b1;
            end
            S_BRANCH: begin
                ctrl_o.alu_a  = ASRC_A;
                ctrl_o.alu_b  = BSRC_B;
                ctrl_o.alu_op = ALU_SUB;
                ctrl_o.pc_src = PCSRC_ALUOUT;
                ctrl_o.pc_we  = alu_zero;
            end
            S_WB_R: ctrl_o.rf_we = 1'b1;
            S_WB_I: begin
                ctrl_o.rf_we  = 1'b1;
                ctrl_o.rf_dst = DST_RT;
            end
            S_MEM_RD: begin
                ctrl_o.mem_src = MADDR_ALUOUT;
                ctrl_o.mdr_we  = 1'b1;
            end
            S_MEM_WR: begin
                ctrl_o.mem_src = MADDR_ALUOUT;
                ctrl_o.mem_we  = 1'b1;
            end
            S_WB_LD: begin
                ctrl_o.rf_we  = 1'b1;
                ctrl_o.rf_dst = DST_RT;
                ctrl_o.rf_src = WSRC_MDR;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_BRANCH_THREE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BRANCH) |=> (state_q == S_FETCH)); // R7
    AST_STORE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o.mem_we |=> !ctrl_o.mem_we); // R6
    AST_LOAD_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WB_LD) |-> ($past(state_q) == S_MEM_RD)); // R5

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata
);

    localparam int AW   = $clog2(NREG);
    localparam int STEP = XLEN / 8;

    ctrl_t           ctrl;
    state_t          state;
    logic [XLEN-1:0] pc, ir, a_q, b_q, aluout_q, mdr_q;
    logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, imm_sx, rf_wdata;
    logic [AW-1:0]   rf_waddr;
    logic            alu_zero;

    mc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (ir[31:26]),
        .funct    (ir[5:0]),
        .alu_zero (alu_zero),
        .ctrl_o   (ctrl),
        .state_o  (state)
    );

    assign imm_sx   = {{(XLEN-16){ir[15]}}, ir[15:0]};
    assign rf_waddr = (ctrl.rf_dst == DST_RD) ? ir[15:11] : ir[20:16];
    assign rf_wdata = (ctrl.rf_src == WSRC_MDR) ? mdr_q : aluout_q;

    mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (ir[25:21]),
        .rd_addr_b (ir[20:16]),
        .rd_data_a (rf_a),
        .rd_data_b (rf_b),
        .wr_en     (ctrl.rf_we),
        .wr_addr   (rf_waddr),
        .wr_data   (rf_wdata)
    );

    assign alu_a = (ctrl.alu_a == ASRC_PC) ? pc : a_q;

    always_comb begin
        unique case (ctrl.alu_b)
            BSRC_B:     alu_b = b_q;
            BSRC_STEP:  alu_b = XLEN'(STEP);
            BSRC_IMM:   alu_b = imm_sx;
            BSRC_BRIMM: alu_b = imm_sx << 2;
            default:    alu_b = '0;
        endcase
    end

    mc_alu #(.XLEN(XLEN)) u_alu (
        .op_a   (alu_a),
        .op_b   (alu_b),
        .op     (ctrl.alu_op),
        .result (alu_y),
        .zero   (alu_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= '0;
            ir       <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            mdr_q    <= '0;
        end else begin
            if (ctrl.pc_we)     pc       <= (ctrl.pc_src == PCSRC_ALUOUT) ? aluout_q : alu_y;
            if (ctrl.ir_we)     ir       <= mem_rdata;
            if (ctrl.ab_we)     a_q      <= rf_a;
            if (ctrl.ab_we)     b_q      <= rf_b;
            if (ctrl.aluout_we) aluout_q <= alu_y;
            if (ctrl.mdr_we)    mdr_q    <= mem_rdata;
        end
    end

    assign mem_addr  = (ctrl.mem_src == MADDR_ALUOUT) ? aluout_q : pc;
    assign mem_wdata = b_q;
    assign mem_we    = ctrl.mem_we;

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> (pc == $past(pc) + XLEN'(STEP))); // R2
    AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> (ir == $past(mem_rdata))); // R2
    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRANCH && a_q == b_q) |=> (pc == $past(aluout_q))); // R7
    AST_ILLEGAL_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_DECODE && state == S_FETCH) |-> (pc == $past(pc))); // R9
    AST_WE_ONLY_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == S_MEM_WR && ir[31:26] == OP_SW)); // R10

endmodule

// File: tb/mc_core_bench.sv
module mc_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    always #5 clk = ~clk;

    mc_core u_mc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
        logic        chk;
        int          req;
    } bus_t;

    bus_t        q[$];
    logic [31:0] mreg [32];
    logic [31:0] mmem [256];
    logic [31:0] mpc;
    int          halts = 0;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic void push(logic [31:0] a, logic w, logic [31:0] d, logic c, int r);
        bus_t e;
        e.addr = a; e.we = w; e.wdata = d; e.chk = c; e.req = r;
        q.push_back(e);
    endfunction

    // Instruction-level model: emits the expected bus activity for one instruction.
    task automatic model_step();
        logic [31:0] ins, sx, npc, va, vb, res, ea;
        int rs, rt, rd;
        ins = mmem[mpc[9:2]];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        sx = {{16{ins[15]}}, ins[15:0]};
        va = mreg[rs]; vb = mreg[rt];
        npc = mpc + 32'd4;
        push(mpc, 1'b0, '0, 1'b1, 2);   // R2 fetch
        push('0, 1'b0, '0, 1'b0, 2);    // decode
        if (ins == enc_i(6'h04, 0, 0, -1)) halts++;
        case (ins[31:26])
            6'h00: begin // R3
                case (ins[5:0])
                    6'h20: res = va + vb;
                    6'h22: res = va - vb;
                    6'h24: res = va & vb;
                    6'h25: res = va | vb;
                    6'h2A: res = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
                    default: res = 'x;
                endcase
                if (ins[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A}) begin
                    push('0, 1'b0, '0, 1'b0, 3);
                    push('0, 1'b0, '0, 1'b0, 3);
                    if (rd != 0) mreg[rd] = res; // R8
                end // otherwise R9: nothing more
            end
            6'h08: begin // R4
                push('0, 1'b0, '0, 1'b0, 4);
                push('0, 1'b0, '0, 1'b0, 4);
                if (rt != 0) mreg[rt] = va + sx;
            end
            6'h23: begin // R5
                ea = va + sx;
                push('0, 1'b0, '0, 1'b0, 5);
                push(ea, 1'b0, '0, 1'b1, 5);
                push('0, 1'b0, '0, 1'b0, 5);
                if (rt != 0) mreg[rt] = mmem[ea[9:2]];
            end
            6'h2B: begin // R6
                ea = va + sx;
                push('0, 1'b0, '0, 1'b0, 6);
                push(ea, 1'b1, vb, 1'b1, 6);
                mmem[ea[9:2]] = vb;
            end
            6'h04: begin // R7
                push('0, 1'b0, '0, 1'b0, 7);
                if (va == vb) npc = npc + (sx << 2);
            end
            default: ; // R9
        endcase
        mpc = npc;
    endtask

    task automatic check_word(int idx, logic [31:0] exp, string req);
        checks++;
        if (mem[idx] !== exp) begin
            errors++;
            $display("FAIL %s mem[%0d]: actual=%h expected=%h", req, idx, mem[idx], exp);
        end
    endtask

    initial begin
        logic [31:0] prog [28];
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        prog[0]  = enc_i(6'h08, 0, 1, 5);
        prog[1]  = enc_i(6'h08, 0, 2, -3);          // R4 negative immediate
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(1, 2, 4, 6'h22);
        prog[4]  = enc_r(1, 2, 5, 6'h24);
        prog[5]  = enc_r(1, 2, 6, 6'h25);
        prog[6]  = enc_r(2, 1, 7, 6'h2A);
        prog[7]  = enc_r(1, 2, 8, 6'h2A);
        prog[8]  = enc_i(6'h08, 1, 0, 7);           // R8 write to r0
        prog[9]  = enc_i(6'h08, 0, 10, 32'h150);
        prog[10] = enc_i(6'h23, 10, 11, -16);       // R5 negative offset
        prog[11] = enc_i(6'h23, 10, 0, -16);        // R8 load into r0
        prog[12] = enc_i(6'h04, 1, 2, 3);           // R7 not taken
        prog[13] = enc_i(6'h04, 1, 1, 1);           // R7 taken
        prog[14] = enc_i(6'h08, 0, 12, 99);
        prog[15] = 32'hFC00_0000;                   // R9 unknown opcode
        prog[16] = enc_r(1, 2, 13, 6'h3F);          // R9 unknown funct
        prog[17] = enc_i(6'h2B, 0, 3, 32'h100);
        prog[18] = enc_i(6'h2B, 0, 4, 32'h104);
        prog[19] = enc_i(6'h2B, 0, 0, 32'h108);
        prog[20] = enc_i(6'h2B, 0, 11, 32'h10C);
        prog[21] = enc_i(6'h2B, 0, 12, 32'h110);
        prog[22] = enc_i(6'h2B, 0, 13, 32'h114);
        prog[23] = enc_i(6'h2B, 0, 6, 32'h118);
        prog[24] = enc_i(6'h2B, 0, 7, 32'h11C);
        prog[25] = enc_i(6'h2B, 0, 5, 32'h120);
        prog[26] = enc_i(6'h2B, 0, 8, 32'h124);
        prog[27] = enc_i(6'h04, 0, 0, -1);          // halt loop, backward branch
        for (int i = 0; i < 28; i++) mem[i] = prog[i];
        mem[80] = 32'hCAFE_F00D;
        for (int i = 0; i < 256; i++) mmem[i] = mem[i];
        mpc = '0;

        repeat (3) @(negedge clk);
        checks++;                                   // R1 reset state
        if (mem_addr !== 32'd0 || mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual addr=%h we=%b expected addr=0 we=0", mem_addr, mem_we);
        end
        rst_n = 1'b1;

        while (!(halts >= 3 && q.size() == 0)) begin
            bus_t e;
            if (q.size() == 0) model_step();
            e = q.pop_front();
            checks++;
            if (mem_we !== e.we || (e.chk && mem_addr !== e.addr) ||
                (e.we && mem_wdata !== e.wdata)) begin
                errors++;
                $display("FAIL R%0d bus: actual addr=%h we=%b wdata=%h expected addr=%h we=%b wdata=%h",
                         e.req, mem_addr, mem_we, mem_wdata, e.addr, e.we, e.wdata);
            end
            @(negedge clk);
        end

        check_word(64, 32'd2, "R3 add");
        check_word(65, 32'd8, "R3 sub");
        check_word(66, 32'd0, "R8 r0 after writes");
        check_word(67, 32'hCAFE_F00D, "R5 load");
        check_word(68, 32'd0, "R7 skipped instruction");
        check_word(69, 32'd0, "R9 illegal funct no write");
        check_word(70, 32'hFFFF_FFFD, "R3 or");
        check_word(71, 32'd1, "R3 slt true");
        check_word(72, 32'd5, "R3 and");
        check_word(73, 32'd0, "R3 slt false");
        for (int i = 64; i < 80; i++) check_word(i, mmem[i], "R6 store image");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=hung expected=halt loop reached");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule